// File: doc/BRIEF.md
# Row-Parallel Tap and Error Memory

This block is the weight store of one neural stage. It keeps the stage's taps and its back-propagated error values together in a single banked memory. Each row is as wide as the number of neurons in the stage, and each neuron lane has a bank of its own. A full row feeds the parallel multiply-accumulate array in one access, and the update logic can reach any single lane of any row without disturbing its neighbours.

The address space is split into two fixed regions. Tap rows start at row 0. Error rows follow directly after the last tap row. Every write carries a region tag. A write whose row falls outside the tagged region is dropped and reported with a one-cycle flag. There are two identical ports, A and B, both clocked at the stage rate. Each port can read and write full rows or single lanes on its own.

Top module: `tap_err_mem`

## Requirements
- R1: Rows 0 to TAP_ROWS-1 form the tap region. Rows TAP_ROWS to TAP_ROWS+ERR_ROWS-1 form the error region. The port address is the physical row number.
- R2: A full-row write (`x_full`=1) stores lane j of `x_wdata` (bits j*LANE_W upward) into lane j of the addressed row. A read returns lane j of the row in the same bit field of `x_rrow`.
- R3: A single-lane write (`x_full`=0) stores the low LANE_W bits of `x_wdata` into lane `x_lane` of the addressed row only. Every other lane of that row keeps its value.
- R4: `x_rlane` returns the lane selected by `x_lane` from the row that the same access read. It appears in the same cycle as `x_rrow`.
- R5: Read data appears one clock after the access. When a read hits a row that is written in the same cycle, it returns the old contents.
- R6: A write is rejected when its row lies outside the region named by `x_region`. A row at or beyond the total depth is also rejected. A rejected write changes no lane, and `x_viol` is high for exactly the one cycle after it.
- R7: When both ports write the same lane of the same row in one cycle, port A's data is kept. Writes to different lanes of the same row are both kept.
- R8: Both ports operate independently in the same cycle, including reads of two different rows.
- R9: After reset, every row reads as zero, and `x_rrow`, `x_rlane` and `x_viol` are zero.
- R10: While `x_en` is low, the port neither reads nor writes, and its read outputs hold their last value.
- R11: The region code is 0 for the tap region and 1 for the error region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stage clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read-only (0) |
| a_full | input | 1 | Port A full-row (1) or single-lane (0) access |
| a_region | input | 1 | Port A region tag: 0 tap, 1 error |
| a_addr | input | AW | Port A physical row |
| a_lane | input | LW | Port A lane index |
| a_wdata | input | LANES*LANE_W | Port A write data |
| a_rrow | output | LANES*LANE_W | Port A full-row read data |
| a_rlane | output | LANE_W | Port A selected-lane read data |
| a_viol | output | 1 | Port A region violation pulse |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read-only (0) |
| b_full | input | 1 | Port B full-row (1) or single-lane (0) access |
| b_region | input | 1 | Port B region tag: 0 tap, 1 error |
| b_addr | input | AW | Port B physical row |
| b_lane | input | LW | Port B lane index |
| b_wdata | input | LANES*LANE_W | Port B write data |
| b_rrow | output | LANES*LANE_W | Port B full-row read data |
| b_rlane | output | LANE_W | Port B selected-lane read data |
| b_viol | output | 1 | Port B region violation pulse |

## Verification
Full-row writes use a distinct value in every lane. A lane swap or a bit-field shift therefore shows up as a wrong lane, not as a silent match. A single-lane write placed over a known full row shows whether the write enables touch only the chosen lane. Violation writes are tried from the tap side, from the error side and from beyond the depth, which tells a wrong region boundary apart from a missing depth check. Same-cycle writes from both ports, first to the same lane and then to different lanes, separate port priority from lane masking. A read placed in the cycle of a write shows the read-before-write order.

// File: rtl/tem_pkg.sv
package tem_pkg;

    typedef enum logic {
        REGION_TAP = 1'b0,
        REGION_ERR = 1'b1
    } region_e;

    function automatic int lane_bits(input int lanes);
        return (lanes > 1) ? $clog2(lanes) : 1;
    endfunction

    function automatic int row_bits(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/tem_port_map.sv
module tem_port_map
    import tem_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int TAP_ROWS = 8,
    parameter int ERR_ROWS = 4,
    localparam int DEPTH   = TAP_ROWS + ERR_ROWS,
    localparam int AW      = row_bits(DEPTH),
    localparam int LW      = lane_bits(LANES)
) (
    input  logic             en,
    input  logic             we,
    input  logic             full,
    input  logic             region,
    input  logic [AW-1:0]    addr,
    input  logic [LW-1:0]    lane,
    output logic             rd_en,
    output logic             viol,
    output logic [LANES-1:0] lane_wen
);

    localparam logic [AW:0] TAP_LIMIT   = (AW+1)'(TAP_ROWS);
    localparam logic [AW:0] DEPTH_LIMIT = (AW+1)'(DEPTH);

    logic    wr_req;
    logic    in_tap;
    logic    in_depth;
    logic    region_ok;
    region_e reg_tag;

    always_comb begin
        reg_tag   = region_e'(region);
        wr_req    = en & we;
        in_tap    = {1'b0, addr} < TAP_LIMIT;
        in_depth  = {1'b0, addr} < DEPTH_LIMIT;
        region_ok = (reg_tag == REGION_TAP) ? in_tap : (in_depth & ~in_tap);
        viol      = wr_req & ~region_ok;
        rd_en     = en;
    end

    for (genvar j = 0; j < LANES; j++) begin : g_wen
        assign lane_wen[j] = wr_req & region_ok & (full | (lane == LW'(j)));
    end

endmodule

// File: rtl/tem_lane_bank.sv
module tem_lane_bank
    import tem_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int DEPTH  = 12,
    localparam int AW    = row_bits(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_re,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [LANE_W-1:0] a_wd,
    input  logic              b_re,
    input  logic              b_we,
    input  logic [AW-1:0]     b_addr,
    input  logic [LANE_W-1:0] b_wd,
    output logic [LANE_W-1:0] a_q,
    output logic [LANE_W-1:0] b_q
);

    localparam logic [AW:0] DEPTH_LIMIT = (AW+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][LANE_W-1:0] mem;
        logic [LANE_W-1:0]            qa;
        logic [LANE_W-1:0]            qb;
    } bank_t;

    bank_t st_d, st_q;
    logic  a_ok, b_ok;

    always_comb begin
        a_ok = {1'b0, a_addr} < DEPTH_LIMIT;
        b_ok = {1'b0, b_addr} < DEPTH_LIMIT;
        st_d = st_q;
        if (a_re) st_d.qa = a_ok ? st_q.mem[a_addr] : '0;
        if (b_re) st_d.qb = b_ok ? st_q.mem[b_addr] : '0;
        if (b_we && b_ok) st_d.mem[b_addr] = b_wd;
        if (a_we && a_ok) st_d.mem[a_addr] = a_wd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_q = st_q.qa;
    assign b_q = st_q.qb;

    a_r7_port_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (a_we && b_we && a_ok && a_addr == b_addr)
        |=> st_q.mem[$past(a_addr)] == $past(a_wd));

    a_r10_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> $stable(a_q));

    a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> $stable(b_q));

    a_r6_no_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_we && !b_we) |=> $stable(st_q.mem));

endmodule

// File: rtl/tap_err_mem.sv
module tap_err_mem
    import tem_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int LANE_W   = 16,
    parameter int TAP_ROWS = 8,
    parameter int ERR_ROWS = 4,
    localparam int DEPTH   = TAP_ROWS + ERR_ROWS,
    localparam int AW      = row_bits(DEPTH),
    localparam int LW      = lane_bits(LANES),
    localparam int ROW_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic              a_we,
    input  logic              a_full,
    input  logic              a_region,
    input  logic [AW-1:0]     a_addr,
    input  logic [LW-1:0]     a_lane,
    input  logic [ROW_W-1:0]  a_wdata,
    output logic [ROW_W-1:0]  a_rrow,
    output logic [LANE_W-1:0] a_rlane,
    output logic              a_viol,
    input  logic              b_en,
    input  logic              b_we,
    input  logic              b_full,
    input  logic              b_region,
    input  logic [AW-1:0]     b_addr,
    input  logic [LW-1:0]     b_lane,
    input  logic [ROW_W-1:0]  b_wdata,
    output logic [ROW_W-1:0]  b_rrow,
    output logic [LANE_W-1:0] b_rlane,
    output logic              b_viol
);

    typedef struct packed {
        logic          a_viol;
        logic          b_viol;
        logic [LW-1:0] a_lane;
        logic [LW-1:0] b_lane;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             a_rd, b_rd;
    logic             a_bad, b_bad;
    logic [LANES-1:0] a_wen, b_wen;

    tem_port_map #(.LANES(LANES), .TAP_ROWS(TAP_ROWS), .ERR_ROWS(ERR_ROWS)) u_map_a (
        .en(a_en), .we(a_we), .full(a_full), .region(a_region),
        .addr(a_addr), .lane(a_lane),
        .rd_en(a_rd), .viol(a_bad), .lane_wen(a_wen)
    );

    tem_port_map #(.LANES(LANES), .TAP_ROWS(TAP_ROWS), .ERR_ROWS(ERR_ROWS)) u_map_b (
        .en(b_en), .we(b_we), .full(b_full), .region(b_region),
        .addr(b_addr), .lane(b_lane),
        .rd_en(b_rd), .viol(b_bad), .lane_wen(b_wen)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [LANE_W-1:0] a_wd, b_wd;
        assign a_wd = a_full ? a_wdata[j*LANE_W +: LANE_W] : a_wdata[LANE_W-1:0];
        assign b_wd = b_full ? b_wdata[j*LANE_W +: LANE_W] : b_wdata[LANE_W-1:0];

        tem_lane_bank #(.LANE_W(LANE_W), .DEPTH(DEPTH)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .a_re(a_rd), .a_we(a_wen[j]), .a_addr(a_addr), .a_wd(a_wd),
            .b_re(b_rd), .b_we(b_wen[j]), .b_addr(b_addr), .b_wd(b_wd),
            .a_q(a_rrow[j*LANE_W +: LANE_W]),
            .b_q(b_rrow[j*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.a_viol = a_bad;
        ctl_d.b_viol = b_bad;
        if (a_en) ctl_d.a_lane = a_lane;
        if (b_en) ctl_d.b_lane = b_lane;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        a_rlane = '0;
        b_rlane = '0;
        for (int j = 0; j < LANES; j++) begin
            if (ctl_q.a_lane == LW'(j)) a_rlane = a_rrow[j*LANE_W +: LANE_W];
            if (ctl_q.b_lane == LW'(j)) b_rlane = b_rrow[j*LANE_W +: LANE_W];
        end
    end

    assign a_viol = ctl_q.a_viol;
    assign b_viol = ctl_q.b_viol;

    always_comb begin
        if (rst_n) begin
            a_r6_reject_a: assert (!(a_bad && (a_wen != '0)));
            a_r6_reject_b: assert (!(b_bad && (b_wen != '0)));
            a_r3_lane_only_a: assert (a_full || ($countones(a_wen) <= 1));
            a_r3_lane_only_b: assert (b_full || ($countones(b_wen) <= 1));
        end
    end

    a_r6_pulse_needs_write_a: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && a_we) |=> !a_viol);

    a_r6_pulse_needs_write_b: assert property (@(posedge clk) disable iff (!rst_n)
        !(b_en && b_we) |=> !b_viol);

    a_r2_full_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we && a_full && !a_bad) |-> (a_wen == '1));

endmodule

// File: tb/sim_tap_err_mem.sv
module sim_tap_err_mem;

    localparam int CLK_PERIOD = 10;
    localparam int LANES  = 4;
    localparam int LANE_W = 16;
    localparam int TAPS   = 8;
    localparam int ERRS   = 4;
    localparam int DEPTH  = TAPS + ERRS;
    localparam int AW     = 4;
    localparam int LW     = 2;
    localparam int ROW_W  = LANES * LANE_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_en, a_we, a_full, a_region;
    logic [AW-1:0] a_addr;
    logic [LW-1:0] a_lane;
    logic [ROW_W-1:0] a_wdata, a_rrow;
    logic [LANE_W-1:0] a_rlane;
    logic a_viol;
    logic b_en, b_we, b_full, b_region;
    logic [AW-1:0] b_addr;
    logic [LW-1:0] b_lane;
    logic [ROW_W-1:0] b_wdata, b_rrow;
    logic [LANE_W-1:0] b_rlane;
    logic b_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [ROW_W-1:0] model [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_err_mem #(.LANES(LANES), .LANE_W(LANE_W), .TAP_ROWS(TAPS), .ERR_ROWS(ERRS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_full(a_full), .a_region(a_region),
        .a_addr(a_addr), .a_lane(a_lane), .a_wdata(a_wdata),
        .a_rrow(a_rrow), .a_rlane(a_rlane), .a_viol(a_viol),
        .b_en(b_en), .b_we(b_we), .b_full(b_full), .b_region(b_region),
        .b_addr(b_addr), .b_lane(b_lane), .b_wdata(b_wdata),
        .b_rrow(b_rrow), .b_rlane(b_rlane), .b_viol(b_viol)
    );

    task automatic check(input string req, input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        a_en = 0; a_we = 0; a_full = 0; a_region = 0; a_addr = '0; a_lane = '0; a_wdata = '0;
        b_en = 0; b_we = 0; b_full = 0; b_region = 0; b_addr = '0; b_lane = '0; b_wdata = '0;
    endtask

    task automatic port_a(input logic we, input logic full, input logic region,
                          input int addr, input int lane, input logic [ROW_W-1:0] wd);
        a_en = 1; a_we = we; a_full = full; a_region = region;
        a_addr = AW'(addr); a_lane = LW'(lane); a_wdata = wd;
    endtask

    task automatic port_b(input logic we, input logic full, input logic region,
                          input int addr, input int lane, input logic [ROW_W-1:0] wd);
        b_en = 1; b_we = we; b_full = full; b_region = region;
        b_addr = AW'(addr); b_lane = LW'(lane); b_wdata = wd;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic [LANE_W-1:0] lane_of(input logic [ROW_W-1:0] row, input int j);
        return row[j*LANE_W +: LANE_W];
    endfunction

    task automatic read_a(input int addr, input int lane, input string req);
        idle(); port_a(0, 1, 0, addr, lane, '0); step(); idle();
        check(req, a_rrow, model[addr]);
        check(req, ROW_W'(a_rlane), ROW_W'(lane_of(model[addr], lane)));
    endtask

    task automatic t_reset();
        check("R9", a_rrow, '0);
        check("R9", ROW_W'({a_viol, b_viol}), '0);
        read_a(0, 0, "R9");
        read_a(DEPTH-1, 3, "R9");
    endtask

    task automatic t_full_row();
        logic [ROW_W-1:0] v = 64'h4444_3333_2222_1111;
        idle(); port_a(1, 1, 0, 2, 0, v); step(); idle();
        model[2] = v;
        port_b(0, 1, 0, 2, 3, '0); step(); idle();
        check("R2", b_rrow, v);
        check("R4", ROW_W'(b_rlane), ROW_W'(16'h4444));
    endtask

    task automatic t_single_lane();
        idle(); port_b(1, 0, 0, 2, 1, 64'h0000_0000_0000_beef); step(); idle();
        model[2][1*LANE_W +: LANE_W] = 16'hbeef;
        read_a(2, 1, "R3");
        read_a(2, 2, "R4");
    endtask

    task automatic t_read_before_write();
        logic [ROW_W-1:0] v = 64'haaaa_bbbb_cccc_dddd;
        idle(); port_a(1, 1, 0, 3, 0, v); step(); idle();
        check("R5", a_rrow, model[3]);
        model[3] = v;
        read_a(3, 0, "R5");
    endtask

    task automatic t_error_region();
        logic [ROW_W-1:0] v = 64'h0e03_0e02_0e01_0e00;
        idle(); port_b(1, 1, 1, TAPS, 0, v); step(); idle();
        check("R11", ROW_W'(b_viol), '0);
        model[TAPS] = v;
        read_a(TAPS, 2, "R1");
    endtask

    task automatic t_violation();
        idle(); port_a(1, 1, 0, TAPS+1, 0, '1); step(); idle();
        check("R6", ROW_W'(a_viol), 1);
        step();
        check("R6", ROW_W'(a_viol), 0);
        read_a(TAPS+1, 0, "R6");
        port_b(1, 0, 1, 2, 0, 64'h1234); step(); idle();
        check("R6", ROW_W'(b_viol), 1);
        read_a(2, 0, "R6");
        port_a(1, 1, 1, DEPTH+1, 0, '1); step(); idle();
        check("R6", ROW_W'(a_viol), 1);
        read_a(DEPTH-1, 0, "R6");
    endtask

    task automatic t_collision();
        idle();
        port_a(1, 1, 0, 5, 0, 64'h1111_1111_1111_1111);
        port_b(1, 1, 0, 5, 0, 64'h2222_2222_2222_2222);
        step(); idle();
        model[5] = 64'h1111_1111_1111_1111;
        read_a(5, 0, "R7");
        port_a(1, 0, 0, 5, 0, 64'h00a0);
        port_b(1, 0, 0, 5, 2, 64'h00b2);
        step(); idle();
        model[5][0 +: LANE_W] = 16'h00a0;
        model[5][2*LANE_W +: LANE_W] = 16'h00b2;
        read_a(5, 2, "R7");
    endtask

    task automatic t_dual_read();
        idle(); port_a(0, 1, 0, 2, 0, '0); port_b(0, 1, 0, TAPS, 1, '0); step(); idle();
        check("R8", a_rrow, model[2]);
        check("R8", b_rrow, model[TAPS]);
    endtask

    task automatic t_enable_low();
        logic [ROW_W-1:0] held;
        idle(); port_a(0, 1, 0, 3, 0, '0); step(); idle();
        held = a_rrow;
        a_addr = AW'(2); a_we = 1; a_full = 1; a_wdata = '1; step(); idle();
        check("R10", a_rrow, held);
        read_a(2, 0, "R10");
    endtask

    initial begin
        for (int r = 0; r < DEPTH; r++) model[r] = '0;
        idle();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_full_row();
        t_single_lane();
        t_read_before_write();
        t_error_region();
        t_violation();
        t_collision();
        t_dual_read();
        t_enable_low();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule